// File: doc/BRIEF.md
# Scaled-Index Address ALU

This unit computes the scaled-index and zero-extended-word sums that 64-bit code uses to form addresses. Source one can be doubled, quadrupled or multiplied by eight and then added to source two. In the word forms, only the low 32 bits of source one are used, zero-extended to 64 bits before the shift. A separate operation shifts the zero-extended low word left by an immediate amount. Every sum wraps modulo 2^64. There is no carry or overflow output, and no operation raises an exception.

The unit can be driven in two ways. In the first, the caller supplies a three-bit operation code, the immediate shift and the destination index directly. In the second, `raw_mode` is asserted and the unit takes the operation, shift amount and destination from a 32-bit instruction word. Any instruction word the unit does not recognise is flagged. The write-enable is suppressed for unrecognised instructions and whenever the destination index is zero, so register zero is never written. The parameter `OUT_REG` selects between a registered output stage with one cycle of latency and a purely combinational path.

Top module: `agu_alu`

## Requirements
- R1: Operation code 0 (zero-extended add) gives `{32'b0, src_a[31:0]} + src_b`, modulo 2^64.
- R2: Operation codes 1, 3 and 5 give `(src_a << N) + src_b` with N equal to 1, 2 and 3 respectively. Bits shifted above bit 63 are lost, and the sum wraps.
- R3: Operation codes 2, 4 and 6 give `({32'b0, src_a[31:0]} << N) + src_b` with N equal to 1, 2 and 3. The upper half of `src_a` has no effect on the result.
- R4: Operation code 7 gives `{32'b0, src_a[31:0]} << shamt_imm[5:0]`. `src_b` has no effect on the result, and shift amounts 0 and 63 are both honoured.
- R5: `wr_en` is high only for a valid, recognised operation whose destination index is nonzero. `result` is still presented when the destination is zero.
- R6: With `raw_mode` high, the unit decodes `instr` as follows. Major opcode 0110011 with funct7 0010000 and funct3 010/100/110 selects codes 1/3/5. Major opcode 0111011 with funct7 0000100 and funct3 000 selects code 0. Major opcode 0111011 with funct7 0010000 and funct3 010/100/110 selects codes 2/4/6. Major opcode 0011011 with funct3 001 and bits [31:26] equal to 000010 selects code 7, with the shift amount taken from bits [25:20]. The destination is taken from bits [11:7]. Any other valid word raises `unhandled`, forces `result` to 0 and keeps `wr_en` low.
- R7: With `OUT_REG=1`, `out_valid`, `result`, `wr_en`, `unhandled` and `dest_out` follow the inputs one clock later. With `OUT_REG=0`, they follow in the same cycle.
- R8: While `rst` is high, the registered stage holds `out_valid`, `wr_en`, `unhandled`, `result` and `dest_out` at zero.
- R9: With `OUT_REG=1`, a cycle with `in_valid` low leaves `result` and `dest_out` unchanged and drives `out_valid`, `wr_en` and `unhandled` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| raw_mode | input | 1 | Take operation, shift and destination from `instr` |
| op_sel | input | 3 | Pre-decoded operation code (0 to 7) |
| instr | input | 32 | Raw instruction word, used when `raw_mode` is high |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| shamt_imm | input | 6 | Immediate shift amount for code 7 |
| dest_idx | input | 5 | Destination register index |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Computed value |
| wr_en | output | 1 | Register write-enable |
| dest_out | output | 5 | Destination index that goes with the result |
| unhandled | output | 1 | Raw instruction word not recognised |

## Verification
The bench builds two copies of the unit side by side, one with `OUT_REG=1` and one with `OUT_REG=0`, and drives both with the same stimulus. The combinational copy checks the arithmetic in the same cycle. The registered copy brings the one-cycle latency, the reset values and the hold behaviour on idle cycles within reach. Both copies run `XLEN=64`, so the zero-extension at bit 32 and wrap-around at bit 63 are exercised at their real positions. The raw decoding path is driven with every supported encoding and with an unknown opcode.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    OP_ADDW   = 3'd0,
    OP_SC1    = 3'd1,
    OP_SC1W   = 3'd2,
    OP_SC2    = 3'd3,
    OP_SC2W   = 3'd4,
    OP_SC3    = 3'd5,
    OP_SC3W   = 3'd6,
    OP_SHLW   = 3'd7
  } agu_op_e;

  localparam logic [6:0] MAJ_REG    = 7'b0110011;
  localparam logic [6:0] MAJ_REG32  = 7'b0111011;
  localparam logic [6:0] MAJ_IMM32  = 7'b0011011;
  localparam logic [6:0] F7_SCALE   = 7'b0010000;
  localparam logic [6:0] F7_ADDW    = 7'b0000100;
  localparam logic [5:0] F6_SHLW    = 6'b000010;

  function automatic logic op_is_word(agu_op_e op);
    return (op == OP_ADDW) || (op == OP_SC1W) || (op == OP_SC2W) ||
           (op == OP_SC3W) || (op == OP_SHLW);
  endfunction

  function automatic logic [1:0] op_scale(agu_op_e op);
    case (op)
      OP_SC1, OP_SC1W: return 2'd1;
      OP_SC2, OP_SC2W: return 2'd2;
      OP_SC3, OP_SC3W: return 2'd3;
      default:         return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
#(
  parameter int IW   = 32,
  parameter int SHW  = 6,
  parameter int IDXW = 5
) (
  input  logic [IW-1:0]   instr,
  output agu_op_e         op,
  output logic [SHW-1:0]  shamt,
  output logic [IDXW-1:0] dest,
  output logic            known
);
  logic [6:0] major;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] f6;
  logic       unused_rs1;

  assign major      = instr[6:0];
  assign f3         = instr[14:12];
  assign f7         = instr[31:25];
  assign f6         = instr[31:26];
  assign shamt      = instr[20 +: SHW];
  assign dest       = instr[7 +: IDXW];
  assign unused_rs1 = ^instr[19:15];

  always_comb begin
    op    = OP_ADDW;
    known = 1'b0;
    case (major)
      MAJ_REG: begin
        if (f7 == F7_SCALE) begin
          case (f3)
            3'b010:  begin op = OP_SC1; known = 1'b1; end
            3'b100:  begin op = OP_SC2; known = 1'b1; end
            3'b110:  begin op = OP_SC3; known = 1'b1; end
            default: known = 1'b0;
          endcase
        end
      end
      MAJ_REG32: begin
        if (f7 == F7_ADDW && f3 == 3'b000) begin
          op = OP_ADDW; known = 1'b1;
        end else if (f7 == F7_SCALE) begin
          case (f3)
            3'b010:  begin op = OP_SC1W; known = 1'b1; end
            3'b100:  begin op = OP_SC2W; known = 1'b1; end
            3'b110:  begin op = OP_SC3W; known = 1'b1; end
            default: known = 1'b0;
          endcase
        end
      end
      MAJ_IMM32: begin
        if (f3 == 3'b001 && f6 == F6_SHLW) begin
          op = OP_SHLW; known = 1'b1;
        end
      end
      default: known = 1'b0;
    endcase
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD   = 32,
  parameter int NSCALE = 4
) (
  input  agu_op_e                   op,
  input  logic [XLEN-1:0]           a,
  input  logic [XLEN-1:0]           b,
  input  logic [$clog2(XLEN)-1:0]   shamt,
  input  logic                      handled,
  output logic [XLEN-1:0]           res
);
  localparam int PADW = XLEN - WORD;

  logic [XLEN-1:0] low_zext;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] scaled [NSCALE];
  logic [XLEN-1:0] picked;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] shl;

  assign low_zext = {{PADW{1'b0}}, a[WORD-1:0]};
  assign base     = op_is_word(op) ? low_zext : a;

  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign scaled[k] = base << k;
  end

  assign picked = scaled[op_scale(op)];
  assign sum    = picked + b;
  assign shl    = base << shamt;

  always_comb begin
    if (!handled)           res = '0;
    else if (op == OP_SHLW) res = shl;
    else                    res = sum;
  end

endmodule

// File: rtl/agu_outstage.sv
module agu_outstage #(
  parameter int XLEN    = 64,
  parameter int IDXW    = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_in,
  input  logic [XLEN-1:0] res_in,
  input  logic            we_in,
  input  logic            unh_in,
  input  logic [IDXW-1:0] dest_in,
  output logic            v_out,
  output logic [XLEN-1:0] res_out,
  output logic            we_out,
  output logic            unh_out,
  output logic [IDXW-1:0] dest_out
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_out    <= 1'b0;
        we_out   <= 1'b0;
        unh_out  <= 1'b0;
        res_out  <= '0;
        dest_out <= '0;
      end else begin
        v_out   <= v_in;
        we_out  <= we_in;
        unh_out <= unh_in;
        if (v_in) begin
          res_out  <= res_in;
          dest_out <= dest_in;
        end
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign v_out      = v_in;
    assign we_out     = we_in;
    assign unh_out    = unh_in;
    assign res_out    = res_in;
    assign dest_out   = dest_in;
  end

endmodule

// File: rtl/agu_alu.sv
module agu_alu
  import agu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD    = 32,
  parameter int IDXW    = 5,
  parameter int IW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    raw_mode,
  input  logic [2:0]              op_sel,
  input  logic [IW-1:0]           instr,
  input  logic [XLEN-1:0]         src_a,
  input  logic [XLEN-1:0]         src_b,
  input  logic [$clog2(XLEN)-1:0] shamt_imm,
  input  logic [IDXW-1:0]         dest_idx,
  output logic                    out_valid,
  output logic [XLEN-1:0]         result,
  output logic                    wr_en,
  output logic [IDXW-1:0]         dest_out,
  output logic                    unhandled
);
  localparam int SHW = $clog2(XLEN);

  agu_op_e         dec_op;
  logic [SHW-1:0]  dec_sh;
  logic [IDXW-1:0] dec_rd;
  logic            dec_ok;

  agu_op_e         op_use;
  logic [SHW-1:0]  sh_use;
  logic [IDXW-1:0] rd_use;
  logic            ok_use;
  logic [XLEN-1:0] res_c;
  logic            we_c;
  logic            unh_c;

  agu_decode #(.IW(IW), .SHW(SHW), .IDXW(IDXW)) u_dec (
    .instr (instr),
    .op    (dec_op),
    .shamt (dec_sh),
    .dest  (dec_rd),
    .known (dec_ok)
  );

  assign op_use = raw_mode ? dec_op : agu_op_e'(op_sel);
  assign sh_use = raw_mode ? dec_sh : shamt_imm;
  assign rd_use = raw_mode ? dec_rd : dest_idx;
  assign ok_use = raw_mode ? dec_ok : 1'b1;

  agu_datapath #(.XLEN(XLEN), .WORD(WORD), .NSCALE(4)) u_dp (
    .op      (op_use),
    .a       (src_a),
    .b       (src_b),
    .shamt   (sh_use),
    .handled (ok_use),
    .res     (res_c)
  );

  assign we_c  = in_valid & ok_use & (rd_use != '0);
  assign unh_c = in_valid & raw_mode & ~dec_ok;

  agu_outstage #(.XLEN(XLEN), .IDXW(IDXW), .OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .v_in     (in_valid),
    .res_in   (res_c),
    .we_in    (we_c),
    .unh_in   (unh_c),
    .dest_in  (rd_use),
    .v_out    (out_valid),
    .res_out  (result),
    .we_out   (wr_en),
    .unh_out  (unhandled),
    .dest_out (dest_out)
  );

endmodule

// File: rtl/agu_alu_chk.sv
module agu_alu_chk #(
  parameter int XLEN    = 64,
  parameter int IDXW    = 5,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            unhandled,
  input logic [IDXW-1:0] dest_out
);
  // R5
  x0_guard_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (dest_out != '0));

  // R5
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);

  // R6
  unhandled_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!wr_en && result == '0 && out_valid));

  if (OUT_REG) begin : g_reg_chk
    // R7
    lat_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    // R7
    lat_fall_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(dest_out) && !wr_en && !unhandled));
  end

endmodule

bind agu_alu agu_alu_chk #(.XLEN(XLEN), .IDXW(IDXW), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .result    (result),
  .wr_en     (wr_en),
  .unhandled (unhandled),
  .dest_out  (dest_out)
);

// File: tb/agu_alu_tb.sv
`timescale 1ns/1ps
module agu_alu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, raw_mode;
  logic [2:0]  op_sel;
  logic [31:0] instr;
  logic [63:0] src_a, src_b;
  logic [5:0]  shamt_imm;
  logic [4:0]  dest_idx;

  logic        ov_r, we_r, un_r, ov_c, we_c, un_c;
  logic [63:0] res_r, res_c;
  logic [4:0]  rd_r, rd_c;

  int checks = 0;
  int fails  = 0;
  logic [63:0] last_res;
  logic [4:0]  last_rd;

  always #2 clk = ~clk;

  agu_alu #(.OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_mode(raw_mode),
    .op_sel(op_sel), .instr(instr), .src_a(src_a), .src_b(src_b),
    .shamt_imm(shamt_imm), .dest_idx(dest_idx), .out_valid(ov_r),
    .result(res_r), .wr_en(we_r), .dest_out(rd_r), .unhandled(un_r));

  agu_alu #(.OUT_REG(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_mode(raw_mode),
    .op_sel(op_sel), .instr(instr), .src_a(src_a), .src_b(src_b),
    .shamt_imm(shamt_imm), .dest_idx(dest_idx), .out_valid(ov_c),
    .result(res_c), .wr_en(we_c), .dest_out(rd_c), .unhandled(un_c));

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] sh);
    logic [63:0] z;
    z = {32'h0, a[31:0]};
    case (op)
      3'd0: return z + b;
      3'd1: return (a << 1) + b;
      3'd2: return (z << 1) + b;
      3'd3: return (a << 2) + b;
      3'd4: return (z << 2) + b;
      3'd5: return (a << 3) + b;
      3'd6: return (z << 3) + b;
      default: return z << sh;
    endcase
  endfunction

  function automatic logic [31:0] encode(input logic [2:0] op, input logic [4:0] rd,
                                         input logic [5:0] sh);
    case (op)
      3'd0: return {7'b0000100, 5'd2, 5'd1, 3'b000, rd, 7'b0111011};
      3'd1: return {7'b0010000, 5'd2, 5'd1, 3'b010, rd, 7'b0110011};
      3'd2: return {7'b0010000, 5'd2, 5'd1, 3'b010, rd, 7'b0111011};
      3'd3: return {7'b0010000, 5'd2, 5'd1, 3'b100, rd, 7'b0110011};
      3'd4: return {7'b0010000, 5'd2, 5'd1, 3'b100, rd, 7'b0111011};
      3'd5: return {7'b0010000, 5'd2, 5'd1, 3'b110, rd, 7'b0110011};
      3'd6: return {7'b0010000, 5'd2, 5'd1, 3'b110, rd, 7'b0111011};
      default: return {6'b000010, sh, 5'd1, 3'b001, rd, 7'b0011011};
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One transaction; bad=1 in raw mode sends an unknown opcode.
  task automatic apply(input string req, input logic v, input logic raw, input logic bad,
                       input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] sh, input logic [4:0] rd);
    logic [63:0] er;
    logic        ew, eu;
    @(negedge clk);
    in_valid = v; raw_mode = raw; src_a = a; src_b = b; dest_idx = rd;
    if (raw) begin
      op_sel = $urandom % 8;
      shamt_imm = $urandom % 64;
      instr = bad ? 32'hFFFF_FFFF : encode(op, rd, sh);
    end else begin
      op_sel = op; shamt_imm = sh; instr = $urandom;
    end
    er = (raw && bad) ? 64'h0 : model(op, a, b, sh);
    ew = v && !(raw && bad) && (rd != 0);
    eu = v && raw && bad;
    #1;
    if (v) begin
      chk(req, "comb result", res_c, er);
      chk(req, "comb wr_en", {63'h0, we_c}, {63'h0, ew});
      chk(req, "comb unhandled", {63'h0, un_c}, {63'h0, eu});
      if (!(raw && bad)) chk(req, "comb dest", {59'h0, rd_c}, {59'h0, rd});
    end
    @(posedge clk); #1;
    chk("R7", "reg out_valid", {63'h0, ov_r}, {63'h0, v});
    if (v) begin
      chk(req, "reg result", res_r, er);
      chk(req, "reg wr_en", {63'h0, we_r}, {63'h0, ew});
      chk(req, "reg unhandled", {63'h0, un_r}, {63'h0, eu});
      last_res = er;
      last_rd  = (raw && bad) ? 5'd31 : rd;
      if (!(raw && bad)) chk("R7", "reg dest", {59'h0, rd_r}, {59'h0, rd});
      else last_rd = rd_r;
    end else begin
      chk("R9", "held result", res_r, last_res);
      chk("R9", "held dest", {59'h0, rd_r}, {59'h0, last_rd});
      chk("R9", "idle wr_en", {63'h0, we_r}, 64'h0);
      chk("R9", "idle unhandled", {63'h0, un_r}, 64'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb;
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; in_valid = 0; raw_mode = 0; op_sel = 0; instr = 0;
    src_a = 0; src_b = 0; shamt_imm = 0; dest_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state of registered copy
    chk("R8", "reset out_valid", {63'h0, ov_r}, 64'h0);
    chk("R8", "reset result", res_r, 64'h0);
    chk("R8", "reset wr_en", {63'h0, we_r}, 64'h0);
    chk("R8", "reset unhandled", {63'h0, un_r}, 64'h0);
    chk("R8", "reset dest", {59'h0, rd_r}, 64'h0);
    @(negedge clk); rst = 1'b0;
    last_res = 0; last_rd = 0;

    // R1: upper half of a dropped, sign bit of low word not extended
    apply("R1", 1, 0, 0, 3'd0, 64'hDEAD_BEEF_8000_0000, 64'h1, 6'd0, 5'd3);
    apply("R1", 1, 0, 0, 3'd0, '1, '1, 6'd0, 5'd4);
    // R2: plain scaled add, wrap at 64 bits
    apply("R2", 1, 0, 0, 3'd1, '1, 64'h5, 6'd0, 5'd5);
    apply("R2", 1, 0, 0, 3'd3, 64'hC000_0000_0000_0001, 64'h10, 6'd0, 5'd6);
    apply("R2", 1, 0, 0, 3'd5, '1, '1, 6'd0, 5'd7);
    // R3: word scaled add
    apply("R3", 1, 0, 0, 3'd2, 64'hFFFF_0000_8000_0000, 64'h0, 6'd0, 5'd8);
    apply("R3", 1, 0, 0, 3'd4, '1, 64'h7, 6'd0, 5'd9);
    apply("R3", 1, 0, 0, 3'd6, 64'h1234_5678_FFFF_FFFF, '1, 6'd0, 5'd10);
    // R4: shift 0 and 63, src_b ignored
    apply("R4", 1, 0, 0, 3'd7, 64'hAAAA_BBBB_8000_0001, '1, 6'd0, 5'd11);
    apply("R4", 1, 0, 0, 3'd7, 64'hAAAA_BBBB_8000_0001, 64'h5A5A, 6'd63, 5'd12);
    apply("R4", 1, 0, 0, 3'd7, '1, 64'h0, 6'd32, 5'd13);
    // R5: destination zero keeps result but no write
    apply("R5", 1, 0, 0, 3'd5, 64'h40, 64'h2, 6'd0, 5'd0);
    // R9: idle cycles hold the registered result
    apply("R9", 0, 0, 0, 3'd1, '1, '1, 6'd0, 5'd17);
    apply("R9", 0, 1, 1, 3'd1, 64'h3, 64'h9, 6'd0, 5'd18);
    // R6: every raw encoding, plus an unknown word
    for (int k = 0; k < 8; k++) begin
      pa = {$urandom, $urandom}; pb = {$urandom, $urandom};
      apply("R6", 1, 1, 0, k[2:0], pa, pb, 6'(k * 9), 5'(k + 1));
    end
    apply("R6", 1, 1, 0, 3'd7, 64'h8000_0001, 64'h0, 6'd63, 5'd0);
    apply("R6", 1, 1, 1, 3'd0, '1, '1, 6'd0, 5'd20);
    apply("R9", 0, 0, 0, 3'd0, 64'h1, 64'h1, 6'd0, 5'd21);

    // Random mix of all paths
    for (int i = 0; i < 400; i++) begin
      logic [2:0] rop;
      logic [5:0] rsh;
      rop = $urandom % 8;
      rsh = (i % 5 == 0) ? 6'd63 : ((i % 7 == 0) ? 6'd0 : 6'($urandom));
      pa  = (i % 6 == 0) ? {$urandom, 32'h8000_0000} : {$urandom, $urandom};
      pb  = (i % 9 == 0) ? '1 : {$urandom, $urandom};
      apply(rop == 0 ? "R1" : (rop == 7 ? "R4" : (rop[0] ? "R2" : "R3")),
            ($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 16) == 0,
            rop, pa, pb, rsh, 5'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule